// File: doc/BRIEF.md
# GPIO Interrupt Register Bank

This block is a bank of general-purpose pins, eight by default, each with its own small group of registers. A plain memory-mapped port reads and writes these registers. Writes take effect on a clock edge. Reads are combinational. For every pin the bank holds an output enable and an output value, and it samples the pad input through a two-flop synchronizer.

Each pin can also act as an interrupt source. It can detect a level or a single edge, and a programmable polarity picks which level or which edge direction. Two separate enables decide what a detected trigger does. The first decides whether the trigger sets the pin's sticky status bit. The second decides whether the trigger, or a pending status, may drive the interrupt. A 3-bit routing code per pin must also select the application processor before that pin can reach the combined, registered summary interrupt output.

Software sets up a pin, waits for the summary line, and reads the status bits of the pins that are enabled. It then clears each status bit by writing a 1 to it.

Top module: `gpio_irq_bank`

## Requirements
- R1: Per-pin registers sit at 0x1000 + 0x10*pin: config at +0x0, in/out at +0x4, interrupt config at +0x8, status at +0xC. The routing register of a pin sits at 0x400 + 4*pin. An address only decodes when addr[1:0] is 0 and the pin index is below the pin count.
- R2: Config bit 9 is the output enable and drives pinOe. In/out bit 1 is the output value and drives pinOut. Both are visible on reads and on the pins in the cycle after the write edge. Other config bits read 0.
- R3: In/out bit 0 reads the synchronized pin input. A change driven before clock edge k reads back after edge k+1.
- R4: Interrupt config bits: 0 interrupt enable, 1 polarity (1 = rising or high, 0 = falling or low), 2 detect mode (1 = edge, 0 = level), 3 status-capture enable. These four bits read back, and all higher bits read 0.
- R5: In edge mode a trigger lasts one cycle and fires only on a synchronized transition in the polarity's direction. The opposite edge never triggers.
- R6: In level mode a trigger is present every cycle that the synchronized input equals the polarity bit.
- R7: A trigger sets status bit 0 only when status-capture enable is 1, whatever the interrupt enable. With capture enable 0 the status bit never sets.
- R8: Writing 1 to status bit 0 clears it. A trigger in the same cycle wins, and in level mode the trigger keeps re-setting the bit. Writing 0 has no effect.
- R9: summaryIrq is high in the cycle after any pin has (trigger or status) with interrupt enable 1 and routing code 4. This includes the case where the status bit stays 0 because capture is disabled.
- R10: Routing code 4 sends a pin to the summary output. Code 7, and every other code, keeps the pin off it.
- R11: After reset every register is 0 except routing, which is 7, and pinOe, pinOut and summaryIrq are 0.
- R12: Reads of unmapped or unaligned addresses return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W (13) | Byte address |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Combinational read data for addr |
| pinIn | input | NUM_PINS (8) | Pad inputs, asynchronous |
| pinOut | output | NUM_PINS (8) | Output values |
| pinOe | output | NUM_PINS (8) | Output enables |
| summaryIrq | output | 1 | Registered combined interrupt |

## Verification
Register writes are due one edge after the write, on both reads and pins. An input change reaches in/out bit 0 two edges later. Status and summaryIrq follow three edges after the input change: two edges for the synchronizer and one for their own register. A summary change caused by a routing, enable or clear write shows one edge after the write. A reference model updates on each rising edge and is compared with every output 3 ns later, so the comparison never races the edge. The directed checks count falling edges against these latencies before they read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OE_BIT   = 9;
  localparam int IN_BIT   = 0;
  localparam int OUT_BIT  = 1;
  localparam int IEN_BIT  = 0;
  localparam int POL_BIT  = 1;
  localparam int EDGE_BIT = 2;
  localparam int RAW_BIT  = 3;
  localparam int ROUTE_W  = 3;
  localparam logic [ROUTE_W-1:0] ROUTE_APP  = 3'd4;
  localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;
  localparam int BANK_BASE  = 'h1000;
  localparam int BANK_STEP  = 'h10;
  localparam int ROUTE_BASE = 'h400;
  localparam int ROUTE_STEP = 4;

  typedef enum logic [2:0] {RD_NONE, RD_CFG, RD_IO, RD_ICFG, RD_STS, RD_ROUTE} rdKind_e;

  typedef struct packed {
    logic cfgWr;
    logic ioWr;
    logic icfgWr;
    logic stsWr;
    logic routeWr;
  } pinStrobe_t;

  typedef struct packed {
    logic               oe;
    logic               outVal;
    logic               ien;
    logic               pol;
    logic               edgeMode;
    logic               raw;
    logic               sts;
    logic [ROUTE_W-1:0] route;
  } pinRegs_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 13,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output pinStrobe_t        strb [NUM_PINS],
  output rdKind_e           rdKind,
  output logic [IDX_W-1:0]  rdIdx
);
  localparam logic [ADDR_W-1:0] BANK_LO  = ADDR_W'(BANK_BASE);
  localparam logic [ADDR_W-1:0] BANK_HI  = ADDR_W'(BANK_BASE + BANK_STEP * NUM_PINS);
  localparam logic [ADDR_W-1:0] ROUTE_LO = ADDR_W'(ROUTE_BASE);
  localparam logic [ADDR_W-1:0] ROUTE_HI = ADDR_W'(ROUTE_BASE + ROUTE_STEP * NUM_PINS);

  logic              aligned, inBank, inRoute;
  logic [ADDR_W-1:0] bankOff, routeOff;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    inBank   = aligned && (addr >= BANK_LO) && (addr < BANK_HI);
    inRoute  = aligned && (addr >= ROUTE_LO) && (addr < ROUTE_HI);
    bankOff  = addr - BANK_LO;
    routeOff = addr - ROUTE_LO;
    rdKind   = RD_NONE;
    rdIdx    = '0;
    if (inBank) begin
      rdIdx = bankOff[4 +: IDX_W];
      case (bankOff[3:2])
        2'd0:    rdKind = RD_CFG;
        2'd1:    rdKind = RD_IO;
        2'd2:    rdKind = RD_ICFG;
        default: rdKind = RD_STS;
      endcase
    end else if (inRoute) begin
      rdIdx  = routeOff[2 +: IDX_W];
      rdKind = RD_ROUTE;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      strb[p] = '0;
      if (wrEn && (rdIdx == IDX_W'(p))) begin
        strb[p].cfgWr   = (rdKind == RD_CFG);
        strb[p].ioWr    = (rdKind == RD_IO);
        strb[p].icfgWr  = (rdKind == RD_ICFG);
        strb[p].stsWr   = (rdKind == RD_STS);
        strb[p].routeWr = (rdKind == RD_ROUTE);
      end
    end
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  pinStrobe_t          strb [NUM_PINS],
  input  logic [DATA_W-1:0]   wrData,
  input  rdKind_e             rdKind,
  input  logic [IDX_W-1:0]    rdIdx,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                summaryIrq
);
  pinRegs_t            regs [NUM_PINS];
  logic [NUM_PINS-1:0] syncA, syncB, prevB, trig, req, eligible;
  logic                unusedWr;

  assign unusedWr = ^{wrData[DATA_W-1:OE_BIT+1], wrData[OE_BIT-1:RAW_BIT+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic riseI, fallI;
    assign riseI   = syncB[i] & ~prevB[i];
    assign fallI   = ~syncB[i] & prevB[i];
    assign trig[i] = regs[i].edgeMode ? (regs[i].pol ? riseI : fallI)
                                      : (syncB[i] == regs[i].pol);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[i]       <= '0;
        regs[i].route <= ROUTE_NONE;
      end else begin
        if (strb[i].cfgWr) regs[i].oe     <= wrData[OE_BIT];
        if (strb[i].ioWr)  regs[i].outVal <= wrData[OUT_BIT];
        if (strb[i].icfgWr) begin
          regs[i].ien      <= wrData[IEN_BIT];
          regs[i].pol      <= wrData[POL_BIT];
          regs[i].edgeMode <= wrData[EDGE_BIT];
          regs[i].raw      <= wrData[RAW_BIT];
        end
        if (strb[i].routeWr) regs[i].route <= wrData[ROUTE_W-1:0];
        if (regs[i].raw && trig[i])              regs[i].sts <= 1'b1;
        else if (strb[i].stsWr && wrData[0])     regs[i].sts <= 1'b0;
      end
    end

    // R7: without capture enable a clear status bit stays clear
    a_r7_no_capture: assert property (@(posedge clk) disable iff (!rstN)
      (!regs[i].raw && !regs[i].sts) |=> !regs[i].sts);
    // R8: a clear with no competing trigger takes effect
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].stsWr && wrData[0] && !trig[i]) |=> !regs[i].sts);
    // R2: output enable follows the config write
    a_r2_oe_write: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].cfgWr |=> (pinOe[i] == $past(wrData[OE_BIT])));
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      eligible[p] = regs[p].ien && (regs[p].route == ROUTE_APP);
      req[p]      = (trig[p] | regs[p].sts) & eligible[p];
      pinOut[p]   = regs[p].outVal;
      pinOe[p]    = regs[p].oe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) summaryIrq <= 1'b0;
    else       summaryIrq <= |req;
  end

  always_comb begin
    rdData = '0;
    case (rdKind)
      RD_CFG:  rdData[OE_BIT] = regs[rdIdx].oe;
      RD_IO: begin
        rdData[IN_BIT]  = syncB[rdIdx];
        rdData[OUT_BIT] = regs[rdIdx].outVal;
      end
      RD_ICFG: begin
        rdData[IEN_BIT]  = regs[rdIdx].ien;
        rdData[POL_BIT]  = regs[rdIdx].pol;
        rdData[EDGE_BIT] = regs[rdIdx].edgeMode;
        rdData[RAW_BIT]  = regs[rdIdx].raw;
      end
      RD_STS:   rdData[0] = regs[rdIdx].sts;
      RD_ROUTE: rdData[ROUTE_W-1:0] = regs[rdIdx].route;
      default:  rdData = '0;
    endcase
  end

  // R9: no eligible pin means no summary in the next cycle
  a_r9_summary_gated: assert property (@(posedge clk) disable iff (!rstN)
    (eligible == '0) |=> !summaryIrq);
  // R12: an undecoded address reads zero
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdKind == RD_NONE) |-> (rdData == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                summaryIrq
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  pinStrobe_t       strb [NUM_PINS];
  rdKind_e          rdKind;
  logic [IDX_W-1:0] rdIdx;

  gpio_irq_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .strb(strb), .rdKind(rdKind), .rdIdx(rdIdx)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdKind(rdKind),
    .rdIdx(rdIdx), .pinIn(pinIn), .rdData(rdData), .pinOut(pinOut),
    .pinOe(pinOe), .summaryIrq(summaryIrq)
  );
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [N-1:0] pinIn = '0;
  logic [N-1:0] pinOut, pinOe;
  logic        summaryIrq;

  int nChecks = 0;
  int nErrors = 0;
  bit run = 0;

  always #5 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .summaryIrq(summaryIrq)
  );

  // behavioural reference state
  bit mS1[N], mS2[N], mPrev[N], mOe[N], mOut[N], mIen[N], mPol[N], mEdge[N], mRaw[N], mSts[N];
  int mRoute[N];
  bit mSum;

  task automatic chk(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // kind: 0 none, 1 cfg, 2 io, 3 icfg, 4 status, 5 route
  function automatic void decode(input int a, output int kind, output int p);
    kind = 0; p = 0;
    if (a % 4 != 0) return;
    if (a >= 'h1000 && a < 'h1000 + 16 * N) begin
      p = (a - 'h1000) / 16;
      kind = 1 + ((a % 16) / 4);
    end else if (a >= 'h400 && a < 'h400 + 4 * N) begin
      p = (a - 'h400) / 4;
      kind = 5;
    end
  endfunction

  function automatic int modelRead(input int a);
    int k, p;
    decode(a, k, p);
    case (k)
      1: return int'(mOe[p]) << 9;
      2: return int'(mS2[p]) | (int'(mOut[p]) << 1);
      3: return int'(mIen[p]) | (int'(mPol[p]) << 1) | (int'(mEdge[p]) << 2) | (int'(mRaw[p]) << 3);
      4: return int'(mSts[p]);
      5: return mRoute[p];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mS1[i] = 0; mS2[i] = 0; mPrev[i] = 0; mOe[i] = 0; mOut[i] = 0;
        mIen[i] = 0; mPol[i] = 0; mEdge[i] = 0; mRaw[i] = 0; mSts[i] = 0;
        mRoute[i] = 7;
      end
      mSum = 0;
    end else begin
      bit t[N];
      bit s;
      int k, p;
      s = 0;
      for (int i = 0; i < N; i++) begin
        if (mEdge[i]) t[i] = mPol[i] ? (mS2[i] && !mPrev[i]) : (!mS2[i] && mPrev[i]);
        else          t[i] = (mS2[i] == mPol[i]);
        if ((t[i] || mSts[i]) && mIen[i] && mRoute[i] == 4) s = 1;
      end
      decode(int'(addr), k, p);
      if (!wrEn) k = 0;
      for (int i = 0; i < N; i++) begin
        if (mRaw[i] && t[i]) mSts[i] = 1;
        else if (k == 4 && p == i && wrData[0]) mSts[i] = 0;
      end
      case (k)
        1: mOe[p] = wrData[9];
        2: mOut[p] = wrData[1];
        3: begin mIen[p] = wrData[0]; mPol[p] = wrData[1]; mEdge[p] = wrData[2]; mRaw[p] = wrData[3]; end
        5: mRoute[p] = int'(wrData[2:0]);
        default: ;
      endcase
      for (int i = 0; i < N; i++) begin
        mPrev[i] = mS2[i]; mS2[i] = mS1[i]; mS1[i] = pinIn[i];
      end
      mSum = s;
    end
  end

  // cycle-by-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (run) begin
      logic [N-1:0] eo, eoe;
      for (int i = 0; i < N; i++) begin eo[i] = mOut[i]; eoe[i] = mOe[i]; end
      chk("R2 pinOut model", pinOut, eo);
      chk("R2 pinOe model", pinOe, eoe);
      chk("R9 summaryIrq model", summaryIrq, mSum);
      chk("R1 rdData model", rdData, modelRead(int'(addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1; addr = 13'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic expectRd(input int a, input int exp, input string tag);
    addr = 13'(a);
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    nErrors++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    waitN(3);
    rstN = 1;
    run = 1;
    // R11 reset state
    expectRd('h400, 7, "R11 route reset");
    expectRd('h1008, 0, "R11 icfg reset");
    chk("R11 summary reset", summaryIrq, 0);
    chk("R11 pinOe reset", pinOe, 0);

    // R2 output enable and value on pin 2
    wr('h1020, 'h2FF);
    wr('h1024, 2);
    expectRd('h1020, 'h200, "R2 cfg readback");
    chk("R2 pinOe", pinOe, 8'h04);
    chk("R2 pinOut", pinOut, 8'h04);

    // R3 synchronizer latency on pin 5
    pinIn[5] = 1;
    @(negedge clk);
    expectRd('h1054, 0, "R3 not yet after one edge");
    @(negedge clk);
    expectRd('h1054, 1, "R3 visible after two edges");

    // R4 interrupt config fields on pin 1
    wr('h1018, 'hF);
    expectRd('h1018, 'hF, "R4 icfg readback");
    wr('h1018, 'hF5);
    expectRd('h1018, 'h5, "R4 high bits dropped");
    wr('h1018, 0);

    // R6/R9 level active-high on pin 3, routed
    wr('h1038, 'hB);
    wr('h40C, 4);
    pinIn[3] = 1;
    waitN(3);
    chk("R9 summary from level", summaryIrq, 1);
    expectRd('h103C, 1, "R6 status from level");
    wr('h103C, 1);
    expectRd('h103C, 1, "R8 level re-sets over clear");
    pinIn[3] = 0;
    waitN(3);
    chk("R9 summary held by status", summaryIrq, 1);
    wr('h103C, 1);
    @(negedge clk);
    chk("R8 summary drops after clear", summaryIrq, 0);
    expectRd('h103C, 0, "R8 status cleared");

    // R7/R9 interrupt without capture on pin 4, rising edge
    wr('h1048, 7);
    wr('h410, 4);
    pinIn[4] = 1;
    waitN(3);
    chk("R9 summary without capture", summaryIrq, 1);
    expectRd('h104C, 0, "R7 status stays clear");
    @(negedge clk);
    chk("R5 edge trigger one cycle", summaryIrq, 0);

    // R10 routing on pin 6
    wr('h1068, 'hB);
    pinIn[6] = 1;
    waitN(4);
    chk("R10 route 7 blocks", summaryIrq, 0);
    expectRd('h106C, 1, "R7 capture without routing");
    wr('h418, 5);
    waitN(2);
    chk("R10 route 5 blocks", summaryIrq, 0);
    wr('h418, 4);
    @(negedge clk);
    chk("R10 route 4 passes", summaryIrq, 1);
    wr('h1068, 'hA);
    @(negedge clk);
    chk("R9 enable clear masks", summaryIrq, 0);
    pinIn[6] = 0;
    wr('h418, 7);

    // R5 falling edge only on pin 7
    wr('h1078, 'hC);
    pinIn[7] = 1;
    waitN(4);
    expectRd('h107C, 0, "R5 rising ignored");
    pinIn[7] = 0;
    waitN(4);
    expectRd('h107C, 1, "R5 falling captured");

    // R8 trigger wins against clear
    wr('h107C, 1);
    expectRd('h107C, 0, "R8 clear");
    pinIn[7] = 1;
    waitN(4);
    pinIn[7] = 0;
    @(negedge clk);
    wr('h107C, 1);
    expectRd('h107C, 1, "R8 trigger beats clear");
    wr('h107C, 0);
    expectRd('h107C, 1, "R8 write zero no effect");
    waitN(2);
    wr('h107C, 1);
    expectRd('h107C, 0, "R8 clear after trigger");

    // R12 unmapped and unaligned accesses
    wr('h1026, 0);
    wr('h1200, -1);
    wr('h0800, -1);
    wr('h0420, 4);
    chk("R12 pinOut kept", pinOut, 8'h04);
    expectRd('h1024, 2, "R12 io kept");
    expectRd('h1200, 0, "R12 read unmapped");
    expectRd('h0420, 0, "R12 read past last pin");
    expectRd('h1022, 0, "R12 read unaligned");

    // mixed traffic against the model
    for (int c = 0; c < 3000; c++) begin
      int p, kd;
      @(negedge clk);
      if ($urandom % 3 == 0) pinIn = N'($urandom);
      p = int'($urandom % N);
      kd = int'($urandom % 7);
      wrEn = ($urandom % 3 == 0);
      wrData = $urandom;
      case (kd)
        0: addr = 13'('h1000 + 16 * p);
        1: addr = 13'('h1004 + 16 * p);
        2: addr = 13'('h1008 + 16 * p);
        3: addr = 13'('h100C + 16 * p);
        4: begin
          addr = 13'('h400 + 4 * p);
          wrData = ($urandom % 2) ? 4 : ($urandom % 8);
        end
        5: addr = 13'('h1000 + 16 * N + 4 * p);
        default: addr = 13'($urandom);
      endcase
    end
    @(negedge clk);
    wrEn = 0;
    waitN(2);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule